// File: doc/BRIEF.md
# 8-bit ALU with condition flags

This block is the combinational arithmetic and logic datapath of an 8-bit accumulator machine. An operation code, two byte operands (`a_i` is the accumulator or the single operand of a unary operation, `b_i` is the second operand) and the current condition-code byte go in. The result byte, a high result byte and the new condition-code byte come out in the same cycle. Instruction decode, register storage and memory access sit around it and are not part of it.

Each operation follows its own flag rule. Every one of the flags half carry (H), negative (N), zero (Z), overflow (V) and carry (C) is either computed from the operation, forced to 0, forced to 1, or passed on unchanged. The interrupt-mask and mode bits of the condition byte always go through untouched. The block has no clock, so it has no stream handshake: the caller presents an operation and takes the answer in the same cycle. The only throttling is the caller's own timing budget.

Top module: `alu8_core`

## Requirements
- R1: Condition bits are C=bit0, V=bit1, Z=bit2, N=bit3, I=bit4, H=bit5, F=bit6, E=bit7. Bits 4, 6 and 7 of `cc_o` always equal those bits of `cc_i`. `res_hi_o` is 0 for every code except MUL (19).
- R2: ADD (0) gives a+b and ADC (1) gives a+b+C, both modulo 256. H is the carry out of bit 3, C is the carry out of bit 7, and V is set when a and b have the same sign and the result sign differs. N and Z follow the result.
- R3: SUB (2) gives a-b and SBC (3) gives a-b-C. C is set on borrow, V on signed overflow, N and Z follow the result, and H is kept.
- R4: NEG (8) gives 0-a. C is set when a is nonzero, V is set when a is 0x80, N and Z follow the result, and H is kept.
- R5: AND (4), OR (5) and EOR (6) combine a with b. LD (20) yields b and TST (17) yields a. All of them update N and Z, clear V, and keep H and C.
- R6: COM (7) yields ~a with V=0, C=1 and N, Z updated. CLR (9) yields 0 with N=0, Z=1, V=0, C=0. Both keep H.
- R7: INC (10) and DEC (11) yield a+1 and a-1. V is set for 0x7F and for 0x80 respectively. N and Z are updated, and C and H are kept.
- R8: ASL (12) shifts a left, filling with 0. ROL (15) shifts left, filling with the old C. For both, the new C is a[7], N and Z follow the result, and V = N xor C of the result.
- R9: LSR (14) shifts right, filling with 0, with N=0, C=a[0], V=C and Z updated. ASR (13) fills with a[7] and ROR (16) fills with the old C. For those two, C=a[0], N and Z are updated, and V is kept.
- R10: DAA (18) adds 0x06 when H=1 or the low nibble exceeds 9. It adds 0x60 when C=1, when the high nibble exceeds 9, or when the high nibble exceeds 8 and the low nibble exceeds 9. C is set exactly when 0x60 was added, N and Z are updated, and V and H are kept.
- R11: MUL (19) forms the unsigned 16-bit product a*b, with the high byte on `res_hi_o` and the low byte on `res_o`. Z is set when the whole product is zero, C equals product bit 7, and N, V and H are kept.
- R12: Codes 21 to 31 are unassigned. They return `res_o`=a and `cc_o`=`cc_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 5 | Operation code |
| a_i | input | 8 | Accumulator / unary operand |
| b_i | input | 8 | Second operand |
| cc_i | input | 8 | Incoming condition-code byte |
| res_o | output | 8 | Result, or low product byte |
| res_hi_o | output | 8 | High product byte (MUL only) |
| cc_o | output | 8 | Updated condition-code byte |

## Verification
Every result and every flag is due zero cycles after its stimulus, because no register lies between the ports. The bench changes the inputs on the falling clock edge and compares all three outputs a quarter period later, before the next rising edge. Each operation is swept over every value of `a_i` with several condition bytes, and the two-operand operations are also swept over a spread of `b_i` values. Expected bytes come from integer arithmetic in the bench.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
  localparam int unsigned DW  = 8;
  localparam int unsigned OPW = 5;
  localparam int unsigned NW  = DW / 2;

  localparam int unsigned CC_C = 0;
  localparam int unsigned CC_V = 1;
  localparam int unsigned CC_Z = 2;
  localparam int unsigned CC_N = 3;
  localparam int unsigned CC_I = 4;
  localparam int unsigned CC_H = 5;
  localparam int unsigned CC_F = 6;
  localparam int unsigned CC_E = 7;

  typedef enum logic [OPW-1:0] {
    OP_ADD = 5'd0,  OP_ADC = 5'd1,  OP_SUB = 5'd2,  OP_SBC = 5'd3,
    OP_AND = 5'd4,  OP_OR  = 5'd5,  OP_EOR = 5'd6,  OP_COM = 5'd7,
    OP_NEG = 5'd8,  OP_CLR = 5'd9,  OP_INC = 5'd10, OP_DEC = 5'd11,
    OP_ASL = 5'd12, OP_ASR = 5'd13, OP_LSR = 5'd14, OP_ROL = 5'd15,
    OP_ROR = 5'd16, OP_TST = 5'd17, OP_DAA = 5'd18, OP_MUL = 5'd19,
    OP_LD  = 5'd20
  } alu_op_e;
endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub
  import alu8_pkg::*;
(
  input  logic [DW-1:0] x_i,
  input  logic [DW-1:0] y_i,
  input  logic          sub_i,
  input  logic          cin_i,
  output logic [DW-1:0] sum_o,
  output logic          c_o,
  output logic          v_o,
  output logic          h_o
);
  logic [DW-1:0] y_eff;
  logic          ci_eff;
  logic [DW:0]   full;
  logic [NW:0]   low;

  always_comb begin
    y_eff  = sub_i ? ~y_i : y_i;
    ci_eff = sub_i ? ~cin_i : cin_i;
    full   = {1'b0, x_i} + {1'b0, y_eff} + {{DW{1'b0}}, ci_eff};
    low    = {1'b0, x_i[NW-1:0]} + {1'b0, y_eff[NW-1:0]} + {{NW{1'b0}}, ci_eff};
    sum_o  = full[DW-1:0];
    c_o    = sub_i ? ~full[DW] : full[DW];
    h_o    = low[NW];
    v_o    = (x_i[DW-1] == y_eff[DW-1]) && (full[DW-1] != x_i[DW-1]);
  end

  // Undoing the operation on the result must give back the first operand.
  always_comb begin
    if (!$isunknown({x_i, y_i, sub_i, cin_i})) begin
      if (sub_i)
        assert_sub_inverse_R3: assert (DW'(sum_o + y_i + {{(DW-1){1'b0}}, cin_i}) == x_i)
          else $error("subtract result does not invert");
      else
        assert_add_inverse_R2: assert (DW'(sum_o - y_i - {{(DW-1){1'b0}}, cin_i}) == x_i)
          else $error("add result does not invert");
    end
  end
endmodule

// File: rtl/alu8_logic.sv
module alu8_logic
  import alu8_pkg::*;
(
  input  alu_op_e       op_i,
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  output logic [DW-1:0] res_o
);
  always_comb begin
    case (op_i)
      OP_AND:  res_o = a_i & b_i;
      OP_OR:   res_o = a_i | b_i;
      OP_EOR:  res_o = a_i ^ b_i;
      OP_COM:  res_o = ~a_i;
      OP_LD:   res_o = b_i;
      default: res_o = a_i;
    endcase
  end

  always_comb begin
    if (!$isunknown({op_i, a_i}) && op_i == OP_COM)
      assert_com_bits_R6: assert ((res_o ^ a_i) == {DW{1'b1}})
        else $error("complement leaves a bit unflipped");
  end
endmodule

// File: rtl/alu8_shift.sv
module alu8_shift
  import alu8_pkg::*;
(
  input  alu_op_e       op_i,
  input  logic [DW-1:0] a_i,
  input  logic          cin_i,
  output logic [DW-1:0] res_o,
  output logic          cout_o
);
  always_comb begin
    res_o  = a_i;
    cout_o = cin_i;
    case (op_i)
      OP_ASL: begin res_o = {a_i[DW-2:0], 1'b0};    cout_o = a_i[DW-1]; end
      OP_ROL: begin res_o = {a_i[DW-2:0], cin_i};   cout_o = a_i[DW-1]; end
      OP_LSR: begin res_o = {1'b0, a_i[DW-1:1]};    cout_o = a_i[0];    end
      OP_ASR: begin res_o = {a_i[DW-1], a_i[DW-1:1]}; cout_o = a_i[0];  end
      OP_ROR: begin res_o = {cin_i, a_i[DW-1:1]};   cout_o = a_i[0];    end
      default: ;
    endcase
  end

  always_comb begin
    if (!$isunknown({op_i, a_i}) && op_i == OP_ASR)
      assert_asr_sign_R9: assert (res_o[DW-1] == a_i[DW-1] && res_o[DW-2] == a_i[DW-1])
        else $error("arithmetic right shift lost the sign");
  end
endmodule

// File: rtl/alu8_bcdmul.sv
module alu8_bcdmul
  import alu8_pkg::*;
(
  input  logic [DW-1:0]   a_i,
  input  logic [DW-1:0]   b_i,
  input  logic            h_i,
  input  logic            c_i,
  output logic [DW-1:0]   daa_o,
  output logic            daa_c_o,
  output logic [2*DW-1:0] prod_o
);
  logic [NW-1:0] lo_n, hi_n;
  logic          fix_lo, fix_hi;

  always_comb begin
    lo_n    = a_i[NW-1:0];
    hi_n    = a_i[DW-1:NW];
    fix_lo  = h_i || (lo_n > NW'(9));
    fix_hi  = c_i || (hi_n > NW'(9)) || ((hi_n > NW'(8)) && (lo_n > NW'(9)));
    daa_o   = a_i + {(fix_hi ? NW'(6) : NW'(0)), (fix_lo ? NW'(6) : NW'(0))};
    daa_c_o = fix_hi;
    prod_o  = (2*DW)'(a_i) * (2*DW)'(b_i);
  end

  always_comb begin
    if (!$isunknown({a_i, b_i}))
      assert_mul_zero_R11: assert ((prod_o == '0) == (a_i == '0 || b_i == '0))
        else $error("product zero does not match operands");
  end
endmodule

// File: rtl/alu8_core.sv
module alu8_core
  import alu8_pkg::*;
(
  input  logic [OPW-1:0] op_i,
  input  logic [DW-1:0]  a_i,
  input  logic [DW-1:0]  b_i,
  input  logic [DW-1:0]  cc_i,
  output logic [DW-1:0]  res_o,
  output logic [DW-1:0]  res_hi_o,
  output logic [DW-1:0]  cc_o
);
  alu_op_e op;
  assign op = alu_op_e'(op_i);

  logic [DW-1:0]   ax, ay, asum, lres, sres, dres;
  logic            asub, acin, ac, av, ah, scout, dc;
  logic [2*DW-1:0] prod;

  always_comb begin
    ax = a_i; ay = b_i; asub = 1'b0; acin = 1'b0;
    case (op)
      OP_ADC: acin = cc_i[CC_C];
      OP_SUB: asub = 1'b1;
      OP_SBC: begin asub = 1'b1; acin = cc_i[CC_C]; end
      OP_NEG: begin ax = '0; ay = a_i; asub = 1'b1; end
      OP_INC: ay = DW'(1);
      OP_DEC: begin ay = DW'(1); asub = 1'b1; end
      default: ;
    endcase
  end

  alu8_addsub u_add (.x_i(ax), .y_i(ay), .sub_i(asub), .cin_i(acin),
                     .sum_o(asum), .c_o(ac), .v_o(av), .h_o(ah));
  alu8_logic  u_log (.op_i(op), .a_i(a_i), .b_i(b_i), .res_o(lres));
  alu8_shift  u_shf (.op_i(op), .a_i(a_i), .cin_i(cc_i[CC_C]),
                     .res_o(sres), .cout_o(scout));
  alu8_bcdmul u_bm  (.a_i(a_i), .b_i(b_i), .h_i(cc_i[CC_H]), .c_i(cc_i[CC_C]),
                     .daa_o(dres), .daa_c_o(dc), .prod_o(prod));

  logic nz;
  always_comb begin
    res_o = a_i; res_hi_o = '0; cc_o = cc_i; nz = 1'b0;
    case (op)
      OP_ADD, OP_ADC: begin
        res_o = asum; nz = 1'b1;
        cc_o[CC_H] = ah; cc_o[CC_V] = av; cc_o[CC_C] = ac;
      end
      OP_SUB, OP_SBC, OP_NEG: begin
        res_o = asum; nz = 1'b1; cc_o[CC_V] = av; cc_o[CC_C] = ac;
      end
      OP_INC, OP_DEC: begin
        res_o = asum; nz = 1'b1; cc_o[CC_V] = av;
      end
      OP_AND, OP_OR, OP_EOR, OP_LD, OP_TST: begin
        res_o = lres; nz = 1'b1; cc_o[CC_V] = 1'b0;
      end
      OP_COM: begin
        res_o = lres; nz = 1'b1; cc_o[CC_V] = 1'b0; cc_o[CC_C] = 1'b1;
      end
      OP_CLR: begin
        res_o = '0; cc_o[CC_N] = 1'b0; cc_o[CC_Z] = 1'b1;
        cc_o[CC_V] = 1'b0; cc_o[CC_C] = 1'b0;
      end
      OP_ASL, OP_ROL: begin
        res_o = sres; nz = 1'b1; cc_o[CC_C] = scout;
        cc_o[CC_V] = sres[DW-1] ^ scout;
      end
      OP_LSR: begin
        res_o = sres; cc_o[CC_N] = 1'b0; cc_o[CC_Z] = (sres == '0);
        cc_o[CC_C] = scout; cc_o[CC_V] = scout;
      end
      OP_ASR, OP_ROR: begin
        res_o = sres; nz = 1'b1; cc_o[CC_C] = scout;
      end
      OP_DAA: begin
        res_o = dres; nz = 1'b1; cc_o[CC_C] = dc;
      end
      OP_MUL: begin
        res_o = prod[DW-1:0]; res_hi_o = prod[2*DW-1:DW];
        cc_o[CC_Z] = (prod == '0); cc_o[CC_C] = prod[DW-1];
      end
      default: ;
    endcase
    if (nz) begin
      cc_o[CC_N] = res_o[DW-1];
      cc_o[CC_Z] = (res_o == '0);
    end
  end

  always_comb begin
    if (!$isunknown({op_i, a_i, b_i, cc_i})) begin
      assert_ctrl_bits_R1: assert (cc_o[CC_E] == cc_i[CC_E] && cc_o[CC_F] == cc_i[CC_F]
                                   && cc_o[CC_I] == cc_i[CC_I])
        else $error("mask/mode bits altered");
      if (op != OP_MUL)
        assert_hi_zero_R1: assert (res_hi_o == '0)
          else $error("high byte nonzero outside multiply");
      if (op_i > OPW'(20))
        assert_unused_kept_R12: assert (cc_o == cc_i && res_o == a_i)
          else $error("unassigned code changed state");
    end
  end
endmodule

// File: tb/sim_alu8_core.sv
module sim_alu8_core;
  localparam int PERIOD = 10;
  localparam int WATCHDOG_CYC = 180000;

  logic       clk = 1'b0;
  logic [4:0] op = '0;
  logic [7:0] a = '0, b = '0, cc = '0;
  logic [7:0] res, res_hi, cc_out;
  int compared = 0, mismatched = 0;
  bit done = 0;

  always #(PERIOD/2) clk = ~clk;

  alu8_core u0 (.op_i(op), .a_i(a), .b_i(b), .cc_i(cc),
                .res_o(res), .res_hi_o(res_hi), .cc_o(cc_out));

  function automatic string req_of(input int o);
    case (o)
      0, 1:             return "R2";
      2, 3:             return "R3";
      8:                return "R4";
      4, 5, 6, 17, 20:  return "R5";
      7, 9:             return "R6";
      10, 11:           return "R7";
      12, 15:           return "R8";
      13, 14, 16:       return "R9";
      18:               return "R10";
      19:               return "R11";
      default:          return "R12";
    endcase
  endfunction

  // Expected {res_hi, res, cc} from the requirement text.
  function automatic logic [23:0] model(input int o, input logic [7:0] x, y, f);
    int ai = x, bi = y, c = f[0], hf = f[5], s, sv, p, lo, hn, adj;
    logic [7:0] r = x, hi = 0, g = f;
    bit nz = 0;
    case (o)
      0, 1: begin
        int ci = (o == 1) ? c : 0;
        s = ai + bi + ci; r = 8'(s); sv = int'($signed(x)) + int'($signed(y)) + ci;
        g[5] = ((ai % 16) + (bi % 16) + ci) > 15; g[0] = s > 255;
        g[1] = (sv > 127) || (sv < -128); nz = 1;
      end
      2, 3: begin
        int ci = (o == 3) ? c : 0;
        s = ai - bi - ci; r = 8'(s); sv = int'($signed(x)) - int'($signed(y)) - ci;
        g[0] = s < 0; g[1] = (sv > 127) || (sv < -128); nz = 1;
      end
      8:  begin r = 8'(0 - ai); g[0] = ai != 0; g[1] = ai == 128; nz = 1; end
      4:  begin r = x & y; g[1] = 0; nz = 1; end
      5:  begin r = x | y; g[1] = 0; nz = 1; end
      6:  begin r = x ^ y; g[1] = 0; nz = 1; end
      20: begin r = y; g[1] = 0; nz = 1; end
      17: begin r = x; g[1] = 0; nz = 1; end
      7:  begin r = 8'(255 - ai); g[1] = 0; g[0] = 1; nz = 1; end
      9:  begin r = 0; g[3] = 0; g[2] = 1; g[1] = 0; g[0] = 0; end
      10: begin r = 8'(ai + 1); g[1] = ai == 127; nz = 1; end
      11: begin r = 8'(ai - 1); g[1] = ai == 128; nz = 1; end
      12, 15: begin
        r = 8'(ai * 2 + ((o == 15) ? c : 0)); g[0] = ai >= 128;
        g[1] = r[7] ^ g[0]; nz = 1;
      end
      14: begin r = 8'(ai / 2); g[0] = ai % 2; g[3] = 0; g[2] = r == 0; g[1] = g[0]; end
      13: begin r = 8'(ai / 2 + ((ai >= 128) ? 128 : 0)); g[0] = ai % 2; nz = 1; end
      16: begin r = 8'(ai / 2 + c * 128); g[0] = ai % 2; nz = 1; end
      18: begin
        lo = ai % 16; hn = ai / 16; adj = 0;
        if (hf == 1 || lo > 9) adj += 6;
        g[0] = (c == 1) || hn > 9 || (hn > 8 && lo > 9);
        if (g[0]) adj += 96;
        r = 8'(ai + adj); nz = 1;
      end
      19: begin
        p = ai * bi; r = 8'(p); hi = 8'(p / 256);
        g[2] = p == 0; g[0] = (p / 128) % 2;
      end
      default: ;
    endcase
    if (nz) begin g[3] = r[7]; g[2] = (r == 0); end
    return {hi, r, g};
  endfunction

  task automatic run(input int o, input logic [7:0] x, y, f);
    logic [23:0] exp;
    @(negedge clk);
    op = 5'(o); a = x; b = y; cc = f;
    #(PERIOD/4);
    exp = model(o, x, y, f);
    compared++;
    if ({res_hi, res, cc_out} !== exp) begin
      mismatched++;
      $display("FAIL %s op=%0d a=%02h b=%02h cc=%02h actual=%06h expected=%06h",
               req_of(o), o, x, y, f, {res_hi, res, cc_out}, exp);
    end
  endtask

  initial begin
    repeat (WATCHDOG_CYC) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    logic [7:0] ccs [4] = '{8'h00, 8'hFF, 8'h21, 8'hD0};
    int bin_ops [9] = '{0, 1, 2, 3, 4, 5, 6, 20, 19};
    // Idle-state check: all-zero inputs give ADD 0+0, Z set (R2).
    run(0, 8'h00, 8'h00, 8'h00);
    // Corner cases: R2 signed overflow, R3 borrow, R11 bit-7 carry, R10 double fix.
    run(0, 8'h7F, 8'h01, 8'h00);
    run(3, 8'h00, 8'hFF, 8'h01);
    run(19, 8'hFF, 8'hFF, 8'hF0);
    run(18, 8'h9A, 8'h00, 8'h00);
    run(8, 8'h80, 8'h00, 8'h00);   // R4
    run(9, 8'h55, 8'h00, 8'hFF);   // R6
    // Two-operand sweeps (R2 R3 R5 R11).
    foreach (bin_ops[k])
      for (int ai = 0; ai < 256; ai++)
        for (int bk = 0; bk <= 24; bk++)
          for (int ci = 0; ci < 2; ci++)
            run(bin_ops[k], 8'(ai), (bk == 24) ? 8'hFF : 8'(bk * 11), ccs[ci]);
    // Single-operand sweeps (R4 R6 R7 R8 R9 R10 R5 for TST).
    for (int o = 7; o <= 18; o++)
      for (int ai = 0; ai < 256; ai++)
        for (int ci = 0; ci < 4; ci++)
          run(o, 8'(ai), 8'h3C, ccs[ci]);
    // Unassigned codes (R12) and pass-through (R1).
    for (int o = 21; o < 32; o++)
      for (int ci = 0; ci < 4; ci++)
        run(o, 8'(o * 7), 8'hA5, ccs[ci]);
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule